// File: doc/BRIEF.md
# Memory-Mapped Integer Divider

This peripheral performs 32-bit integer division behind a small register bus. Software places a numerator and a denominator into two operand registers; any write to either operand launches a fresh division using the present contents of both. Each operand can be reached through two addresses. Both addresses hold the same storage. The address used for the latest operand write sets whether the division treats the operands as unsigned or as two's-complement signed values.

A shift-subtract engine settles four quotient bits per clock, so a 32-bit division finishes eight cycles after the launching write. The quotient and the remainder are then latched into result registers. A status word reports a ready flag and a dirty flag. Software may also write the result registers directly to restore saved context. Such a write cancels any division in flight and leaves the block ready and dirty. Reading the quotient clears the dirty flag, so the remainder is read first.

Top module: `mdiv_top`

## Requirements
- R1: After reset the status word reads READY=1 (bit 0) and DIRTY=0 (bit 1). The operand and result registers read 0.
- R2: The address map is: 0 and 1 are the numerator (unsigned and signed alias), 2 and 3 are the denominator (unsigned and signed alias), 4 is the quotient, 5 is the remainder and 6 is the status word. Both aliases of one operand write and read back the same register.
- R3: A write to any operand address drops READY in the following cycle. READY stays low for exactly 8 cycles after the write edge and is high after the eighth edge that follows it.
- R4: An unsigned division (last operand write at address 0 or 2) yields quotient = N / D and remainder = N % D.
- R5: A signed division (last operand write at address 1 or 3) truncates toward zero. The quotient is negative when the operand signs differ, and the remainder takes the sign of the numerator. The most negative value divided by -1 gives a quotient equal to the most negative value and a remainder of 0.
- R6: A denominator of zero gives remainder = numerator. The quotient is all ones in unsigned mode. In signed mode the quotient is 1 for a negative numerator and all ones (-1) otherwise.
- R7: Starting a division sets DIRTY. A quotient read clears DIRTY. A remainder read leaves DIRTY unchanged.
- R8: A bus write to the quotient or remainder address stores the written value, cancels a division in flight, and sets READY and DIRTY. The cancelled division never overwrites the results afterwards.
- R9: An operand write during a division restarts it from its first step. READY rises 8 cycles after the latest operand write.
- R10: The status word is read-only. A write to address 6 changes neither flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle (side effects only) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The assertions assume that the bus makes at most one access per cycle. A read and a write never share a cycle, and only addresses 0 to 6 carry meaning. The stimulus drives every access from a task that raises exactly one strobe per cycle on the falling edge. The sweep then compares each result with a bench model. That model includes the special cases of a zero denominator and of the most negative value divided by -1.

// File: rtl/mdiv_pkg.sv
package mdiv_pkg;
   typedef enum logic [2:0] {
      REG_UNUM = 3'd0,
      REG_SNUM = 3'd1,
      REG_UDEN = 3'd2,
      REG_SDEN = 3'd3,
      REG_QUOT = 3'd4,
      REG_REM  = 3'd5,
      REG_STAT = 3'd6
   } mdiv_reg_e;
endpackage

// File: rtl/mdiv_negate.sv
module mdiv_negate #(
   parameter int W = 32
) (
   input  logic [W-1:0] val_i,
   input  logic         neg_i,
   output logic [W-1:0] val_o
);
   assign val_o = neg_i ? ((~val_i) + W'(1)) : val_i;
endmodule

// File: rtl/mdiv_engine.sv
module mdiv_engine #(
   parameter int DATA_W        = 32,
   parameter int BITS_PER_STEP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              kill_i,
   input  logic [DATA_W-1:0] num_i,
   input  logic [DATA_W-1:0] den_i,
   output logic              busy_o,
   output logic              last_o,
   output logic [DATA_W-1:0] quo_o,
   output logic [DATA_W-1:0] rem_o
);
   localparam int STEPS = DATA_W / BITS_PER_STEP;
   localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;

   logic [DATA_W-1:0] acc_q, dq_q, den_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              busy_q;

   logic [DATA_W-1:0] acc_c [0:BITS_PER_STEP];
   logic [DATA_W-1:0] dq_c  [0:BITS_PER_STEP];

   assign acc_c[0] = acc_q;
   assign dq_c[0]  = dq_q;

   for (genvar g = 0; g < BITS_PER_STEP; g++) begin : g_stage
      logic [DATA_W:0] trial, diff;
      logic            fits;
      assign trial = {acc_c[g], dq_c[g][DATA_W-1]};
      assign diff  = trial - {1'b0, den_q};
      assign fits  = trial >= {1'b0, den_q};
      assign acc_c[g+1] = fits ? diff[DATA_W-1:0] : trial[DATA_W-1:0];
      assign dq_c[g+1]  = {dq_c[g][DATA_W-2:0], fits};
   end

   assign busy_o = busy_q;
   assign last_o = busy_q && (cnt_q == CNT_W'(STEPS - 1));
   assign quo_o  = dq_c[BITS_PER_STEP];
   assign rem_o  = acc_c[BITS_PER_STEP];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         dq_q   <= '0;
         den_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (kill_i) begin
         busy_q <= 1'b0;
      end else if (start_i) begin
         acc_q  <= '0;
         dq_q   <= num_i;
         den_q  <= den_i;
         cnt_q  <= '0;
         busy_q <= 1'b1;
      end else if (busy_q) begin
         acc_q <= acc_c[BITS_PER_STEP];
         dq_q  <= dq_c[BITS_PER_STEP];
         cnt_q <= cnt_q + CNT_W'(1);
         if (last_o) busy_q <= 1'b0;
      end
   end

   AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !kill_i |=> busy_o && (cnt_q == '0)); // R9
   AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !last_o && !start_i && !kill_i |=> busy_o && (cnt_q == $past(cnt_q) + CNT_W'(1))); // R3
   AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      last_o && !start_i |=> !busy_o); // R3
endmodule

// File: rtl/mdiv_top.sv
module mdiv_top #(
   parameter int DATA_W        = 32,
   parameter int BITS_PER_STEP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [2:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);
   import mdiv_pkg::*;

   if (DATA_W < 2) begin : g_bad_width
      $error("mdiv_top: DATA_W must be at least 2");
   end
   if (BITS_PER_STEP < 1 || (DATA_W % BITS_PER_STEP) != 0) begin : g_bad_step
      $error("mdiv_top: BITS_PER_STEP must divide DATA_W");
   end

   logic [DATA_W-1:0] num_q, den_q, quo_q, rem_q;
   logic              ready_q, dirty_q, qneg_q, rneg_q;

   logic wr_num, wr_den, wr_res, start, op_signed, rd_quot;
   logic [DATA_W-1:0] num_n, den_n, num_mag, den_mag;
   logic neg_num, neg_den;
   logic eng_busy, eng_last;
   logic [DATA_W-1:0] eng_quo, eng_rem, quo_fix, rem_fix;

   assign wr_num    = bus_wr && (bus_addr == REG_UNUM || bus_addr == REG_SNUM);
   assign wr_den    = bus_wr && (bus_addr == REG_UDEN || bus_addr == REG_SDEN);
   assign wr_res    = bus_wr && (bus_addr == REG_QUOT || bus_addr == REG_REM);
   assign start     = wr_num || wr_den;
   assign op_signed = (bus_addr == REG_SNUM) || (bus_addr == REG_SDEN);
   assign rd_quot   = bus_rd && (bus_addr == REG_QUOT);

   assign num_n   = wr_num ? bus_wdata : num_q;
   assign den_n   = wr_den ? bus_wdata : den_q;
   assign neg_num = op_signed && num_n[DATA_W-1];
   assign neg_den = op_signed && den_n[DATA_W-1];

   mdiv_negate #(.W(DATA_W)) u_abs_num (.val_i(num_n),   .neg_i(neg_num), .val_o(num_mag));
   mdiv_negate #(.W(DATA_W)) u_abs_den (.val_i(den_n),   .neg_i(neg_den), .val_o(den_mag));
   mdiv_negate #(.W(DATA_W)) u_fix_quo (.val_i(eng_quo), .neg_i(qneg_q),  .val_o(quo_fix));
   mdiv_negate #(.W(DATA_W)) u_fix_rem (.val_i(eng_rem), .neg_i(rneg_q),  .val_o(rem_fix));

   mdiv_engine #(.DATA_W(DATA_W), .BITS_PER_STEP(BITS_PER_STEP)) u_engine (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .kill_i  (wr_res),
      .num_i   (num_mag),
      .den_i   (den_mag),
      .busy_o  (eng_busy),
      .last_o  (eng_last),
      .quo_o   (eng_quo),
      .rem_o   (eng_rem)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         num_q   <= '0;
         den_q   <= '0;
         quo_q   <= '0;
         rem_q   <= '0;
         ready_q <= 1'b1;
         dirty_q <= 1'b0;
         qneg_q  <= 1'b0;
         rneg_q  <= 1'b0;
      end else if (start) begin
         num_q   <= num_n;
         den_q   <= den_n;
         ready_q <= 1'b0;
         dirty_q <= 1'b1;
         qneg_q  <= neg_num ^ neg_den;
         rneg_q  <= neg_num;
      end else if (wr_res) begin
         if (bus_addr == REG_QUOT) quo_q <= bus_wdata;
         else                      rem_q <= bus_wdata;
         ready_q <= 1'b1;
         dirty_q <= 1'b1;
      end else begin
         if (eng_last) begin
            quo_q   <= quo_fix;
            rem_q   <= rem_fix;
            ready_q <= 1'b1;
         end
         if (rd_quot) dirty_q <= 1'b0;
      end
   end

   always_comb begin
      case (bus_addr)
         REG_UNUM, REG_SNUM: bus_rdata = num_q;
         REG_UDEN, REG_SDEN: bus_rdata = den_q;
         REG_QUOT:           bus_rdata = quo_q;
         REG_REM:            bus_rdata = rem_q;
         REG_STAT:           bus_rdata = {{(DATA_W-2){1'b0}}, dirty_q, ready_q};
         default:            bus_rdata = '0;
      endcase
   end

   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      eng_busy |-> !ready_q); // R3
   AST_START_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> dirty_q && !ready_q); // R7
   AST_QUOT_READ_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      rd_quot && !bus_wr |=> !dirty_q); // R7
   AST_RESULT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_res |=> ready_q && dirty_q && !eng_busy); // R8
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ready_q && !bus_wr |=> $stable(quo_q) && $stable(rem_q)); // R8
   AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == REG_STAT |=> $stable(ready_q) && $stable(dirty_q)); // R10
endmodule

// File: tb/mdiv_top_tb_top.sv
module mdiv_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   mdiv_top dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk);
      #1 bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic expect_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
      logic [31:0] v;
      bus_read(a, v);
      check(req, v, exp);
   endtask

   function automatic logic [63:0] model(input bit sgn, input logic [31:0] n, input logic [31:0] d);
      logic [31:0] q, r;
      if (d == 32'd0) begin
         q = (sgn && n[31]) ? 32'd1 : 32'hFFFF_FFFF;
         r = n;
      end else if (!sgn) begin
         q = n / d;
         r = n % d;
      end else if (n == 32'h8000_0000 && d == 32'hFFFF_FFFF) begin
         q = 32'h8000_0000;
         r = 32'd0;
      end else begin
         q = $signed(n) / $signed(d);
         r = $signed(n) % $signed(d);
      end
      return {q, r};
   endfunction

   task automatic run_op(input bit sgn, input bit num_alias, input logic [31:0] n, input logic [31:0] d);
      logic [63:0] e;
      string tag;
      e = model(sgn, n, d);
      tag = (d == 0) ? "R6" : (sgn ? "R5" : "R4");
      bus_write(num_alias ? 3'd1 : 3'd0, n);
      bus_write(sgn ? 3'd3 : 3'd2, d);
      idle(8);
      expect_reg({tag, " remainder"}, 3'd5, e[31:0]);
      expect_reg({tag, " quotient"}, 3'd4, e[63:32]);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] corner [0:7];
      logic [31:0] seed;
      corner[0] = 32'd0;          corner[1] = 32'd1;
      corner[2] = 32'd7;          corner[3] = 32'hFFFF_FFFF;
      corner[4] = 32'h8000_0000;  corner[5] = 32'h7FFF_FFFF;
      corner[6] = 32'h1234_5678;  corner[7] = 32'hFFFF_FF9C;

      idle(3);
      #1 rst_n = 1'b1;

      // R1 reset state
      expect_reg("R1 status", 3'd6, 32'h1);
      expect_reg("R1 quotient", 3'd4, 32'h0);
      expect_reg("R1 remainder", 3'd5, 32'h0);
      expect_reg("R1 numerator", 3'd0, 32'h0);

      // R2 alias storage
      bus_write(3'd0, 32'hAAAA_5555);
      expect_reg("R2 numerator alias", 3'd1, 32'hAAAA_5555);
      bus_write(3'd3, 32'd3);
      expect_reg("R2 denominator alias", 3'd2, 32'd3);

      // R3 timing, R4 result, R7 dirty handling
      bus_write(3'd0, 32'd100);
      idle(7);
      expect_reg("R3 not ready at 7", 3'd6, 32'h2);
      expect_reg("R3 ready at 8", 3'd6, 32'h3);
      expect_reg("R4 remainder", 3'd5, 32'd1);
      expect_reg("R7 remainder read keeps dirty", 3'd6, 32'h3);
      expect_reg("R4 quotient", 3'd4, 32'd33);
      expect_reg("R7 quotient read clears dirty", 3'd6, 32'h1);

      // R9 restart during calculation
      bus_write(3'd0, 32'd50);
      idle(4);
      bus_write(3'd2, 32'd7);
      idle(7);
      expect_reg("R9 still busy after restart", 3'd6, 32'h2);
      expect_reg("R9 ready 8 after restart", 3'd6, 32'h3);
      expect_reg("R9 remainder", 3'd5, 32'd1);
      expect_reg("R9 quotient", 3'd4, 32'd7);

      // R8 result write aborts
      bus_write(3'd0, 32'd1000);
      idle(2);
      bus_write(3'd4, 32'h0000_DEAD);
      expect_reg("R8 ready and dirty", 3'd6, 32'h3);
      idle(12);
      expect_reg("R8 remainder kept", 3'd5, 32'd1);
      expect_reg("R8 quotient kept", 3'd4, 32'h0000_DEAD);
      expect_reg("R8 dirty cleared by read", 3'd6, 32'h1);
      bus_write(3'd5, 32'h77);
      expect_reg("R8 remainder write", 3'd5, 32'h77);
      expect_reg("R8 flags after remainder write", 3'd6, 32'h3);

      // R10 status is read-only
      bus_write(3'd6, 32'h0);
      expect_reg("R10 status unchanged", 3'd6, 32'h3);

      // R4 R5 R6 sweep over corner pairs in both modes
      for (int s = 0; s < 2; s++)
         for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
               run_op(s[0], i[0] ^ j[0], corner[i], corner[j]);

      seed = 32'h1357_9BDF;
      for (int k = 0; k < 60; k++) begin
         logic [31:0] a, b;
         seed = seed * 32'd1664525 + 32'd1013904223;
         a = seed;
         seed = seed * 32'd1664525 + 32'd1013904223;
         b = seed >> (seed[4:0]);
         run_op(k[0], k[1], a, b);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule